// File: doc/BRIEF.md
# Three-Channel Reloading Tick Timers

This block provides three 8-bit up-counting timers with automatic reload, reached through a small register port with one write channel and one combinational read channel. Each counter steps once per count event. Normally the count event is a tick from a shared prescaler that divides the system clock. When a counter passes its all-ones value, it restarts from its own reload register, raises a sticky flag and emits a one-cycle interrupt pulse.

Timer 0 can instead count rising edges of an external clock pin. That pin is synchronised through two flops, and a two-state edge machine finds the rising edges. Its states are EXT_LOW and EXT_HIGH. The transition EXT_LOW to EXT_HIGH emits one count pulse. The transition EXT_HIGH to EXT_LOW emits nothing. A synchronised, active-high gate input can hold timer 0 when its gate enable is set.

Timers 0 and 1 can be chained into one 16-bit counter. Timer 1 drives a pin that toggles on each of its overflow events. The overflow of one selected timer is exported as a tick for a serial baud generator.

Top module: `tmr_set`

## Requirements
- R1: After reset, every counter, every reload register, the control register and the flags read 0, and all three outputs (toggle, interrupts, baud tick) are low.
- R2: Register addresses are 0, 1 and 2 for reload 0 to 2, 3 for control, 4 for flags, and 5, 6 and 7 for counts 0 to 2. Writing a reload register while its timer is stopped also loads that counter. While the timer runs, the write changes only the reload register.
- R3: Control bits 0, 1 and 2 are the run enables of timers 0, 1 and 2. A running timer adds one per prescaler tick. The prescaler issues one tick every PRESCALE_DIV clocks from reset. A stopped counter holds its value.
- R4: A count event at 0xFF loads the counter from its reload register. In the next cycle that timer's irq_o bit is high for exactly one cycle and its flag (flag bit i for timer i) is set.
- R5: Flags stay set until software writes 1 to the matching bit at address 4. Writing 0 has no effect. An overflow event in the same cycle as a clear leaves the flag set.
- R6: With control bit 3 set, timer 0 counts rising edges of ext_clk_i instead of prescaler ticks. A rising edge is seen after two synchronising flops, and the count changes three clock edges after the pin rises.
- R7: With control bit 4 set, timer 0 counts only while gate_i, delayed by two synchronising flops, is high. With bit 4 clear, gate_i has no effect.
- R8: With control bit 5 set, timers 0 (low byte) and 1 (high byte) form one 16-bit counter run by bit 0 and clocked by timer 0's source. The low byte wraps to 0 and carries into the high byte. At 0xFFFF both bytes reload from {reload 1, reload 0}. Only flag 1 and irq 1 report this overflow.
- R9: tmr1_toggle_o inverts in the cycle after each timer 1 overflow event, including the 16-bit one, and is otherwise stable.
- R10: baud_tick_o pulses for one cycle, in the same cycle as irq_o[BAUD_SEL].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | W | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | W | Read data (combinational) |
| ext_clk_i | input | 1 | External count clock for timer 0 |
| gate_i | input | 1 | Active-high count gate for timer 0 |
| tmr1_toggle_o | output | 1 | Toggles on timer 1 overflow |
| irq_o | output | 3 | One-cycle overflow pulses, one per timer |
| baud_tick_o | output | 1 | Overflow tick of the selected timer |

## Verification
The bench builds the block with W=8, PRESCALE_DIV=2 and BAUD_SEL=2. With a divide of two, an 8-bit wrap takes a few dozen cycles and a full 16-bit cascade wrap takes about 520 cycles. Reload on overflow, the low-byte carry and the 0xFFFF reload can therefore all be seen within one short run. The read address rotates every cycle, so every register and counter is compared against the reference model while the timers run in prescaler, external-edge, gated and cascade modes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [2:0] {
        A_RL0  = 3'd0,
        A_RL1  = 3'd1,
        A_RL2  = 3'd2,
        A_CTRL = 3'd3,
        A_FLAG = 3'd4,
        A_CNT0 = 3'd5,
        A_CNT1 = 3'd6,
        A_CNT2 = 3'd7
    } tmr_addr_e;

    typedef enum logic {
        EXT_LOW  = 1'b0,
        EXT_HIGH = 1'b1
    } ext_state_e;

    localparam int NTMR     = 3;
    localparam int CW       = 6;
    localparam int B_EXTSRC = 3;
    localparam int B_GATEEN = 4;
    localparam int B_CASC   = 5;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && DIV > 1) |=> !tick_o);
endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic gate_i,
    output logic edge_o,
    output logic gate_o
);
    logic       p1_q, p2_q, g1_q, g2_q;
    ext_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1_q <= 1'b0; p2_q <= 1'b0;
            g1_q <= 1'b0; g2_q <= 1'b0;
        end else begin
            p1_q <= pin_i;  p2_q <= p1_q;
            g1_q <= gate_i; g2_q <= g1_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EXT_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        edge_o  = 1'b0;
        unique case (state_q)
            EXT_LOW:  if (p2_q) begin
                          state_d = EXT_HIGH;
                          edge_o  = 1'b1;
                      end
            EXT_HIGH: if (!p2_q) state_d = EXT_LOW;
        endcase
    end

    assign gate_o = g2_q;

    p_edge_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         inc_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] wrap_val_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    assign cnt_o = cnt_q;
    assign ovf_o = run_i && inc_i && (cnt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (run_i && inc_i)   cnt_q <= ovf_o ? wrap_val_i : cnt_q + 1'b1;
        else if (!run_i && load_i) cnt_q <= load_val_i;
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> (cnt_q == $past(cnt_q)));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && inc_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && inc_i && cnt_q == TOP) |=> (cnt_q == $past(wrap_val_i)));
    p_stopped_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && load_i) |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tmr_set.sv
module tmr_set
    import tmr_pkg::*;
#(
    parameter int W            = 8,
    parameter int PRESCALE_DIV = 16,
    parameter int BAUD_SEL     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [2:0]    wr_addr_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic [2:0]    rd_addr_i,
    output logic [W-1:0]  rd_data_o,
    input  logic          ext_clk_i,
    input  logic          gate_i,
    output logic          tmr1_toggle_o,
    output logic [2:0]    irq_o,
    output logic          baud_tick_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0]      rl_q  [NTMR];
    logic [W-1:0]      cnt   [NTMR];
    logic [W-1:0]      wrap  [NTMR];
    logic [CW-1:0]     ctrl_q;
    logic [NTMR-1:0]   flag_q, run_eff, inc, ovf, ld, evt, clr;
    logic              tick, ext_edge, gate_s, casc, src0;

    tmr_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick));

    tmr_ext_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_clk_i), .gate_i(gate_i),
        .edge_o(ext_edge), .gate_o(gate_s));

    assign casc       = ctrl_q[B_CASC];
    assign src0       = (ctrl_q[B_EXTSRC] ? ext_edge : tick)
                        && (!ctrl_q[B_GATEEN] || gate_s);
    assign run_eff[0] = ctrl_q[0];
    assign run_eff[1] = casc ? ctrl_q[0] : ctrl_q[1];
    assign run_eff[2] = ctrl_q[2];
    assign inc[0]     = src0;
    assign inc[1]     = casc ? ovf[0] : tick;
    assign inc[2]     = tick;
    assign wrap[0]    = (casc && cnt[1] != TOP) ? '0 : rl_q[0];
    assign wrap[1]    = rl_q[1];
    assign wrap[2]    = rl_q[2];
    assign evt        = {ovf[2], ovf[1], ovf[0] & ~casc};
    assign clr        = (wr_en_i && wr_addr_i == A_FLAG) ? wr_data_i[NTMR-1:0] : '0;

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        assign ld[i] = wr_en_i && (wr_addr_i == 3'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rl_q[i] <= '0;
            else if (ld[i]) rl_q[i] <= wr_data_i;
        end

        tmr_counter #(.W(W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .run_i(run_eff[i]), .inc_i(inc[i]),
            .load_i(ld[i]), .load_val_i(wr_data_i), .wrap_val_i(wrap[i]),
            .cnt_o(cnt[i]), .ovf_o(ovf[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q        <= '0;
            flag_q        <= '0;
            irq_o         <= '0;
            tmr1_toggle_o <= 1'b0;
            baud_tick_o   <= 1'b0;
        end else begin
            if (wr_en_i && wr_addr_i == A_CTRL) ctrl_q <= wr_data_i[CW-1:0];
            flag_q        <= (flag_q & ~clr) | evt;
            irq_o         <= evt;
            tmr1_toggle_o <= tmr1_toggle_o ^ evt[1];
            baud_tick_o   <= evt[BAUD_SEL];
        end
    end

    always_comb begin
        unique case (tmr_addr_e'(rd_addr_i))
            A_RL0:  rd_data_o = rl_q[0];
            A_RL1:  rd_data_o = rl_q[1];
            A_RL2:  rd_data_o = rl_q[2];
            A_CTRL: rd_data_o = W'(ctrl_q);
            A_FLAG: rd_data_o = W'(flag_q);
            A_CNT0: rd_data_o = cnt[0];
            A_CNT1: rd_data_o = cnt[1];
            A_CNT2: rd_data_o = cnt[2];
        endcase
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> (flag_q[0] && irq_o[0]));
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[1] && !clr[1]) |=> flag_q[1]);
    p_toggle_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |=> (tmr1_toggle_o != $past(tmr1_toggle_o)));
    p_toggle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt[1] |=> $stable(tmr1_toggle_o));
    p_casc_low_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        casc |=> !irq_o[0]);
    p_baud_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick_o |-> irq_o[BAUD_SEL]);
endmodule

// File: tb/tb_tmr_set.sv
module tb_tmr_set;
    localparam int W    = 8;
    localparam int DIV  = 2;
    localparam int BSEL = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic         ext_clk = 1'b0;
    logic         gate = 1'b0;
    logic         tog;
    logic [2:0]   irq;
    logic         baud;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit mon_on = 0;

    tmr_set #(.W(W), .PRESCALE_DIV(DIV), .BAUD_SEL(BSEL)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .ext_clk_i(ext_clk), .gate_i(gate), .tmr1_toggle_o(tog),
        .irq_o(irq), .baud_tick_o(baud));

    always #2 clk = ~clk;

    // behavioural reference model
    int m_cnt [3];
    int m_rl  [3];
    int m_ctrl, m_flag, m_tog, m_irq, m_baud, m_pre;
    int s1, s2, est, g1, g2;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin m_cnt[k] = 0; m_rl[k] = 0; end
            m_ctrl = 0; m_flag = 0; m_tog = 0; m_irq = 0; m_baud = 0; m_pre = 0;
            s1 = 0; s2 = 0; est = 0; g1 = 0; g2 = 0;
        end else begin
            int tick, edg, gok, casc, r[3], i0, v, ev[3], clrm;
            tick  = (m_pre == DIV - 1);
            m_pre = tick ? 0 : m_pre + 1;
            edg   = s2 && !est; est = s2; s2 = s1; s1 = ext_clk;
            gok   = !((m_ctrl >> 4) & 1) || g2; g2 = g1; g1 = gate;
            casc  = (m_ctrl >> 5) & 1;
            r[0]  = m_ctrl & 1;
            r[1]  = casc ? r[0] : (m_ctrl >> 1) & 1;
            r[2]  = (m_ctrl >> 2) & 1;
            i0    = r[0] && (((m_ctrl >> 3) & 1) ? edg : tick) && gok;
            ev[0] = 0; ev[1] = 0; ev[2] = 0;
            if (casc) begin
                v = m_cnt[1] * 256 + m_cnt[0];
                if (i0) begin
                    if (v == 65535) begin v = m_rl[1] * 256 + m_rl[0]; ev[1] = 1; end
                    else v = v + 1;
                end
                m_cnt[1] = v / 256; m_cnt[0] = v % 256;
            end else begin
                if (i0) begin
                    if (m_cnt[0] == 255) begin m_cnt[0] = m_rl[0]; ev[0] = 1; end
                    else m_cnt[0]++;
                end
                if (r[1] && tick) begin
                    if (m_cnt[1] == 255) begin m_cnt[1] = m_rl[1]; ev[1] = 1; end
                    else m_cnt[1]++;
                end
            end
            if (r[2] && tick) begin
                if (m_cnt[2] == 255) begin m_cnt[2] = m_rl[2]; ev[2] = 1; end
                else m_cnt[2]++;
            end
            clrm = 0;
            if (wr_en) begin
                if (wr_addr < 3) begin
                    m_rl[wr_addr] = wr_data;
                    if (!r[wr_addr]) m_cnt[wr_addr] = wr_data;
                end
                else if (wr_addr == 3) m_ctrl = wr_data & 63;
                else if (wr_addr == 4) clrm = wr_data & 7;
            end
            m_irq  = ev[0] + 2 * ev[1] + 4 * ev[2];
            m_flag = (m_flag & ~clrm) | m_irq;
            m_tog  = m_tog ^ ev[1];
            m_baud = ev[BSEL];
        end
    end

    function automatic int exp_rd(int a);
        case (a)
            0, 1, 2: return m_rl[a];
            3:       return m_ctrl;
            4:       return m_flag;
            default: return m_cnt[a - 5];
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge; rotate read address
    always @(negedge clk) begin
        if (mon_on) begin
            string rq;
            rq = (rd_addr < 3) ? "R2" : (rd_addr == 4) ? "R5" : cur_req;
            if (cur_req == "R1") rq = "R1";
            check(rq, rd_data, exp_rd(rd_addr), "rd_data");
            check((cur_req == "R1") ? "R1" : "R4", irq, m_irq, "irq_o");
            check((cur_req == "R1") ? "R1" : "R9", tog, m_tog, "tmr1_toggle_o");
            check((cur_req == "R1") ? "R1" : "R10", baud, m_baud, "baud_tick_o");
            rd_addr <= rd_addr + 3'd1;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        mon_on = 1;
        cur_req = "R1";  idle(10);
        cur_req = "R2";  wr(0, 'hF0); wr(1, 'hFD); wr(2, 'hFE); idle(10);
        cur_req = "R3";  wr(3, 'h01); idle(80);
        cur_req = "R5";  wr(4, 'h00); idle(4); wr(4, 'h01); idle(20);
        cur_req = "R2";  wr(0, 'h10); idle(40);
        cur_req = "R9";  wr(3, 'h07); idle(100);
        cur_req = "R10"; idle(60); wr(4, 'h07); idle(10);
        cur_req = "R6";  wr(3, 'h00); wr(0, 'hF8); wr(3, 'h09);
        for (int k = 0; k < 36; k++) begin idle(5); ext_clk = ~ext_clk; end
        idle(10);
        cur_req = "R7";  wr(3, 'h00); wr(0, 'hF8); gate = 1'b0; wr(3, 'h11); idle(40);
        gate = 1'b1; idle(40); gate = 1'b0; idle(20);
        wr(3, 'h01); idle(30);
        cur_req = "R8";  wr(3, 'h00); wr(0, 'hFE); wr(1, 'hFE); wr(3, 'h21); idle(700);
        finish_run();
    end
endmodule